// File: doc/BRIEF.md
# Slot-Selectable I2S/TDM Serial Data Transmitter

This block sends a stereo pair of 20-bit PCM words out on a single serial data line. It runs as a slave. The bit clock and the frame clock both come from an external master, and the block's only clock input is the bit clock itself. The block captures the frame clock on the rising bit-clock edge. It finds where each frame starts, counts bits and 32-bit slots, and puts each word on the line MSB first. The output changes on the falling bit-clock edge.

A 3-bit mode input chooses one of these formats:
- Two-channel I2S. The left word is sent while the frame clock is low and the right word while it is high. The MSB comes one bit clock after each frame-clock edge.
- TDM with 2, 4 or 8 slots per frame. The frame clock pulses high to mark slot 1. The pair occupies one of four adjacent slot pairs.

Each slot carries only its first 20 bits. Everywhere else the block drops its output enable so that other transmitters can share the line. The number of slots is not configured. It follows from how many bit clocks pass between frame starts.

Top module: `tdm_slot_serializer`

## Requirements
- R1: `mode_sel` codes are: 0 = I2S; 1, 2, 3, 4 = TDM with the pair in slots 1-2, 3-4, 5-6, 7-8 respectively. Codes 5 to 7 keep the line released at all times. The mode is changed only while reset is held.
- R2: A slot is 32 bit clocks long. Only its first 20 bit clocks carry the word, MSB first, bit 19 down to bit 0. The remaining 12 bit clocks are released.
- R3: While released, `sdata_oe` is 0 and `sdata` is 0. During reset, and after reset until the first frame start, the line is released.
- R4: `frame_clk` is sampled on the rising edge of `bclk`. `sdata` and `sdata_oe` change only on the falling edge. The first bit of a word appears on the falling edge that follows the rising edge at which the frame-clock edge is first seen, which is one bit clock after that edge.
- R5: I2S mode:
  - A falling `frame_clk` starts the left word and a rising `frame_clk` starts the right word.
  - Each half may be 32 or more bit clocks long, and only its first 20 are driven.
  - A rising edge seen before any falling edge since reset drives nothing.
- R6: TDM modes: a rising `frame_clk` marks the start of slot 1. The left word goes in the lower slot of the selected pair and the right word in the upper slot.
- R7: TDM frames of 64, 128 and 256 bit clocks hold 2, 4 and 8 slots. If the selected pair lies beyond the end of the frame, the line stays released for the whole frame.
- R8: Both words are sampled at the frame start. In I2S this is the falling frame-clock edge, for both channels. Changes to `left_pcm` or `right_pcm` later in the frame have no effect until the next frame start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Bit clock from the external master; the block's only clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_sel | input | 3 | Format and slot-pair select (see R1) |
| frame_clk | input | 1 | I2S word-select level or TDM frame-start pulse |
| left_pcm | input | 20 | Left PCM word, two's complement |
| right_pcm | input | 20 | Right PCM word, two's complement |
| sdata | output | 1 | Serial data, MSB first; 0 while released |
| sdata_oe | output | 1 | High while the block owns the data line |

## Verification
The bench uses words that differ in every bit position: an isolated MSB and LSB, all ones, all zeros, and alternating patterns. With these, a one-bit shift, a reversed bit order or a swapped channel each show up as a mismatch. I2S is run at 64 and 128 bit clocks per frame. This separates a design that counts each half from the edge that started it from one that assumes fixed 32-bit halves.

TDM is run with every slot pair at frame lengths of 2, 4 and 8 slots. Pairs placed beyond the end of the frame, and reserved codes, must leave the line released for the entire frame. Each frame also changes the PCM inputs a few bits after the frame start, which tells capture-at-frame-start apart from a live path to the inputs.

// File: rtl/sdo_pkg.sv
// Shared definitions for the slot-selectable serial data transmitter.
// Assumes a 3-bit mode code; codes above the last slot pair are reserved.
package sdo_pkg;

    typedef enum logic [2:0] {
        FMT_I2S      = 3'd0,
        FMT_SLOTS_12 = 3'd1,
        FMT_SLOTS_34 = 3'd2,
        FMT_SLOTS_56 = 3'd3,
        FMT_SLOTS_78 = 3'd4
    } fmt_e;

endpackage

// File: rtl/sdo_frame_tracker.sv
// Frame tracker: samples the frame clock on rising bit-clock edges, detects the
// frame start (falling level in I2S, rising level in TDM) and the I2S half change,
// and keeps a saturating bit position within the current frame or half.
// Assumes the frame clock changes on falling bit-clock edges, as a master drives it.
module sdo_frame_tracker #(
    parameter int POS_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             i2s_mode,
    input  logic             frame_clk,
    output logic             frame_start,
    output logic [POS_W-1:0] pos,
    output logic             right_half,
    output logic             synced
);

    localparam logic [POS_W-1:0] POS_LAST = {POS_W{1'b1}};

    logic fclk_q;
    logic half_start;

    // Edge classification of the frame clock against its previous sample.
    always_comb begin
        if (i2s_mode) begin
            frame_start = fclk_q & ~frame_clk;
            half_start  = ~fclk_q & frame_clk;
        end else begin
            frame_start = ~fclk_q & frame_clk;
            half_start  = 1'b0;
        end
    end

    // Position counter, half flag and sync flag; reset loads the live frame level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fclk_q     <= frame_clk;
            pos        <= '0;
            right_half <= 1'b0;
            synced     <= 1'b0;
        end else begin
            fclk_q <= frame_clk;
            if (frame_start) begin
                pos        <= '0;
                right_half <= 1'b0;
                synced     <= 1'b1;
            end else if (half_start) begin
                pos        <= '0;
                right_half <= 1'b1;
            end else if (pos != POS_LAST) begin
                pos <= pos + 1'b1;
            end
        end
    end

endmodule

// File: rtl/sdo_slot_select.sv
// Slot selector: decides from the mode code and the bit position whether the
// current bit belongs to this block, which channel it is, and the bit index
// inside the slot. Purely combinational.
// Assumes slots are 2**BIT_W bits long and WORD_W does not exceed a slot.
module sdo_slot_select #(
    parameter int POS_W  = 8,
    parameter int BIT_W  = 5,
    parameter int WORD_W = 20,
    parameter int NPAIRS = 4,
    parameter int CFG_W  = 3
) (
    input  logic [CFG_W-1:0] mode_sel,
    input  logic [POS_W-1:0] pos,
    input  logic             right_half,
    input  logic             synced,
    output logic             drive_en,
    output logic             chan_right,
    output logic [BIT_W-1:0] bit_idx
);

    localparam int SLOT_IW = POS_W - BIT_W;

    logic [SLOT_IW-1:0] slot;
    logic               in_word;

    assign slot    = pos[POS_W-1:BIT_W];
    assign bit_idx = pos[BIT_W-1:0];
    assign in_word = (int'(bit_idx) < WORD_W);

    // Ownership and channel decode per mode; reserved codes never own a bit.
    always_comb begin
        drive_en   = 1'b0;
        chan_right = 1'b0;
        if (mode_sel == sdo_pkg::FMT_I2S) begin
            drive_en   = synced && (slot == '0) && in_word;
            chan_right = right_half;
        end else if (int'(mode_sel) <= NPAIRS) begin
            drive_en   = synced && in_word && (int'(slot >> 1) == int'(mode_sel) - 1);
            chan_right = slot[0];
        end
    end

endmodule

// File: rtl/sdo_serial_out.sv
// Serial output stage: captures both PCM words at the frame start on the rising
// edge, then on each falling edge registers the selected bit and the output enable.
// Assumes bit_idx counts from the MSB (0) downward and is below WORD_W when drive_en is set.
module sdo_serial_out #(
    parameter int WORD_W = 20,
    parameter int BIT_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] left_in,
    input  logic [WORD_W-1:0] right_in,
    input  logic              drive_en,
    input  logic              chan_right,
    input  logic [BIT_W-1:0]  bit_idx,
    output logic              sdata,
    output logic              sdata_oe
);

    logic [WORD_W-1:0] hold_l;
    logic [WORD_W-1:0] hold_r;
    logic [WORD_W-1:0] word_sel;
    logic [WORD_W-1:0] word_shift;
    logic              bit_val;

    // Word capture at frame start so a word never changes mid-frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_l <= '0;
            hold_r <= '0;
        end else if (load) begin
            hold_l <= left_in;
            hold_r <= right_in;
        end
    end

    // MSB-first bit pick: shift the chosen word left by the bit index.
    always_comb begin
        word_sel   = chan_right ? hold_r : hold_l;
        word_shift = word_sel << bit_idx;
        bit_val    = word_shift[WORD_W-1];
    end

    // Falling-edge launch of data and enable.
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            sdata    <= 1'b0;
            sdata_oe <= 1'b0;
        end else begin
            sdata_oe <= drive_en;
            sdata    <= drive_en & bit_val;
        end
    end

endmodule

// File: rtl/tdm_slot_serializer.sv
// Top level of the slave serial data transmitter. Ties frame tracking, slot
// selection and the output stage together, all clocked by the external bit clock.
// Assumes mode_sel is held constant outside reset.
module tdm_slot_serializer #(
    parameter int WORD_W    = 20,
    parameter int SLOT_W    = 32,
    parameter int MAX_SLOTS = 8,
    parameter int CFG_W     = 3
) (
    input  logic              bclk,
    input  logic              rst_n,
    input  logic [CFG_W-1:0]  mode_sel,
    input  logic              frame_clk,
    input  logic [WORD_W-1:0] left_pcm,
    input  logic [WORD_W-1:0] right_pcm,
    output logic              sdata,
    output logic              sdata_oe
);

    localparam int BIT_W  = $clog2(SLOT_W);
    localparam int POS_W  = $clog2(SLOT_W * MAX_SLOTS);
    localparam int NPAIRS = MAX_SLOTS / 2;

    logic             i2s_mode;
    logic             frame_start;
    logic [POS_W-1:0] pos;
    logic             right_half;
    logic             synced;
    logic             drive_en;
    logic             chan_right;
    logic [BIT_W-1:0] bit_idx;

    assign i2s_mode = (mode_sel == sdo_pkg::FMT_I2S);

    sdo_frame_tracker #(
        .POS_W(POS_W)
    ) u_track (
        .clk        (bclk),
        .rst_n      (rst_n),
        .i2s_mode   (i2s_mode),
        .frame_clk  (frame_clk),
        .frame_start(frame_start),
        .pos        (pos),
        .right_half (right_half),
        .synced     (synced)
    );

    sdo_slot_select #(
        .POS_W (POS_W),
        .BIT_W (BIT_W),
        .WORD_W(WORD_W),
        .NPAIRS(NPAIRS),
        .CFG_W (CFG_W)
    ) u_sel (
        .mode_sel  (mode_sel),
        .pos       (pos),
        .right_half(right_half),
        .synced    (synced),
        .drive_en  (drive_en),
        .chan_right(chan_right),
        .bit_idx   (bit_idx)
    );

    sdo_serial_out #(
        .WORD_W(WORD_W),
        .BIT_W (BIT_W)
    ) u_out (
        .clk       (bclk),
        .rst_n     (rst_n),
        .load      (frame_start),
        .left_in   (left_pcm),
        .right_in  (right_pcm),
        .drive_en  (drive_en),
        .chan_right(chan_right),
        .bit_idx   (bit_idx),
        .sdata     (sdata),
        .sdata_oe  (sdata_oe)
    );

endmodule

// File: rtl/tdm_slot_serializer_checks.sv
// Checker for the serial data transmitter, bound to the top module.
// Samples ports on the rising bit-clock edge, half a bit after the outputs move.
module tdm_slot_serializer_checks #(
    parameter int WORD_W = 20,
    parameter int CFG_W  = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CFG_W-1:0] mode_sel,
    input logic             frame_clk,
    input logic             sdata,
    input logic             sdata_oe
);

    localparam int RUN_W = $clog2(WORD_W) + 2;
    localparam logic [RUN_W-1:0] RUN_TOP = {RUN_W{1'b1}};

    logic [RUN_W-1:0] oe_run;

    // Length of the current unbroken run of driven bits.
    always_ff @(posedge clk) begin
        if (!rst_n)
            oe_run <= '0;
        else if (!sdata_oe)
            oe_run <= '0;
        else if (oe_run != RUN_TOP)
            oe_run <= oe_run + 1'b1;
    end

    // R2: never more than one word's worth of bits driven back to back.
    a_r2_run_limit: assert property (@(posedge clk) disable iff (!rst_n)
        sdata_oe |-> (int'(oe_run) < WORD_W));

    // R1: reserved codes leave the line released.
    a_r1_reserved_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(mode_sel) > 4) |-> !sdata_oe);

    // R5: the left MSB is driven one bit after a falling frame clock in I2S.
    a_r5_i2s_left_msb: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == 3'd0) && $fell(frame_clk) |=> sdata_oe);

    // R6: the slot 1-2 pair starts driving right after the frame pulse.
    a_r6_tdm_slot1_drive: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == 3'd1) && $rose(frame_clk) |=> sdata_oe);

    // R6: higher pairs are released at the first bit of slot 1.
    a_r6_tdm_slot1_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel inside {3'd2, 3'd3, 3'd4}) && $rose(frame_clk) |=> !sdata_oe);

endmodule

bind tdm_slot_serializer tdm_slot_serializer_checks #(
    .WORD_W(WORD_W),
    .CFG_W (CFG_W)
) u_checks (
    .clk      (bclk),
    .rst_n    (rst_n),
    .mode_sel (mode_sel),
    .frame_clk(frame_clk),
    .sdata    (sdata),
    .sdata_oe (sdata_oe)
);

// File: tb/tdm_slot_serializer_test.sv
// Bench: behavioural reference of the serial line, compared after every falling edge.
module tdm_slot_serializer_test;

    localparam int W = 20;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [2:0]   mode = 3'd0;
    logic         fclk = 1'b1;
    logic [W-1:0] lw = '0;
    logic [W-1:0] rw = '0;
    logic         sd;
    logic         oe;
    int           compared = 0;
    int           mismatched = 0;

    always #4 clk = ~clk;

    tdm_slot_serializer uut (
        .bclk     (clk),
        .rst_n    (rst_n),
        .mode_sel (mode),
        .frame_clk(fclk),
        .left_pcm (lw),
        .right_pcm(rw),
        .sdata    (sd),
        .sdata_oe (oe)
    );

    // One comparison of the line against the expected state.
    task automatic check(input string tag, input bit eoe, input bit esd);
        compared++;
        if (oe !== eoe || sd !== esd) begin
            mismatched++;
            $display("FAIL %s: oe=%b sd=%b expected oe=%b sd=%b at %0t",
                     tag, oe, sd, eoe, esd, $time);
        end
    endtask

    // Drive the frame clock for one bit, then check after the falling edge.
    task automatic step(input bit f, input string tag, input bit eoe, input bit esd);
        fclk = f;
        @(posedge clk);
        @(negedge clk);
        #1;
        check(tag, eoe, esd);
    endtask

    // Expected line state for bit k of a frame of len bits.
    function automatic void expect_at(input int k, input int len, input logic [2:0] m,
                                      input logic [W-1:0] L, input logic [W-1:0] R,
                                      output bit eoe, output bit esd);
        eoe = 1'b0;
        esd = 1'b0;
        if (m == 3'd0) begin
            int half = len / 2;
            bit rh = (k >= half);
            int p = rh ? k - half : k;
            if (p < W) begin
                eoe = 1'b1;
                esd = rh ? R[W-1-p] : L[W-1-p];
            end
        end else if (m >= 3'd1 && m <= 3'd4) begin
            int slot = k / 32;
            int b = k % 32;
            int lo = 2 * (int'(m) - 1);
            if (b < W && (slot == lo || slot == lo + 1)) begin
                eoe = 1'b1;
                esd = (slot == lo) ? L[W-1-b] : R[W-1-b];
            end
        end
    endfunction

    // Reset with a new mode and idle frame level, then idle bits (R3).
    task automatic do_reset(input logic [2:0] m, input bit idle);
        @(negedge clk);
        #1;
        rst_n = 1'b0;
        mode = m;
        fclk = idle;
        repeat (3) @(posedge clk);
        @(negedge clk);
        #1;
        check("R3 reset", 1'b0, 1'b0);
        rst_n = 1'b1;
        for (int i = 0; i < 4; i++) step(idle, "R3 pre-sync", 1'b0, 1'b0);
    endtask

    // One full frame; inputs are disturbed at bit 3 to test capture (R8).
    task automatic run_frame(input int len, input logic [W-1:0] L, input logic [W-1:0] R,
                             input string tag);
        for (int k = 0; k < len; k++) begin
            bit f;
            bit eoe;
            bit esd;
            if (k == 0) begin
                lw = L;
                rw = R;
            end else if (k == 3) begin
                lw = ~L;
                rw = ~R;
            end
            f = (mode == 3'd0) ? (k >= len / 2) : (k == 0);
            expect_at(k, len, mode, L, R, eoe, esd);
            step(f, tag, eoe, esd);
        end
    endtask

    initial begin
        // I2S, 64 bit clocks per frame: timing, channels, capture.
        do_reset(3'd0, 1'b1);
        run_frame(64, 20'hA5A5C, 20'h3C0F1, "R4 i2s64");
        run_frame(64, 20'h80001, 20'hFFFFF, "R5 i2s64");
        run_frame(64, 20'h00000, 20'h7FFFE, "R8 i2s64");
        // I2S, 128 bit clocks per frame.
        do_reset(3'd0, 1'b1);
        run_frame(128, 20'h12345, 20'hEDCBA, "R5 i2s128");
        run_frame(128, 20'h55555, 20'hAAAAA, "R2 i2s128");
        // TDM pairs inside the frame.
        do_reset(3'd1, 1'b0);
        run_frame(64, 20'hC0003, 20'h0F0F0, "R6 tdm2 pair12");
        run_frame(64, 20'h80000, 20'h00001, "R8 tdm2 pair12");
        do_reset(3'd2, 1'b0);
        run_frame(128, 20'h9E3A1, 20'h47B2C, "R6 tdm4 pair34");
        do_reset(3'd4, 1'b0);
        run_frame(256, 20'hFFFFF, 20'h80001, "R7 tdm8 pair78");
        run_frame(256, 20'h2468A, 20'hFDB97, "R2 tdm8 pair78");
        do_reset(3'd3, 1'b0);
        run_frame(256, 20'h13579, 20'hECA86, "R6 tdm8 pair56");
        // Pairs beyond the frame end stay released.
        do_reset(3'd4, 1'b0);
        run_frame(128, 20'hFFFFF, 20'hFFFFF, "R7 tdm4 pair78");
        do_reset(3'd2, 1'b0);
        run_frame(64, 20'hFFFFF, 20'hFFFFF, "R7 tdm2 pair34");
        // Reserved codes.
        do_reset(3'd5, 1'b0);
        run_frame(256, 20'hFFFFF, 20'hFFFFF, "R1 code5");
        do_reset(3'd7, 1'b0);
        run_frame(64, 20'hFFFFF, 20'hFFFFF, "R1 code7");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule